// File: doc/BRIEF.md
# Multi-Mode Barrel Shift Unit

This block shifts one data word by a variable amount in one of five ways: three kinds of left shift and two kinds of right shift. Two of the left shifts are "arithmetic" variants with different fill rules. One copies the original lowest bit into every vacated low position. The other holds the sign bit in place, shifts only the bits below it, and reports when significant bits are lost.

The shift amount runs from zero up to the data width. Larger values that fit in the amount port act as a full-width shift. A build-time parameter picks between a purely combinational result and one registered behind a single flop stage. The block has no state machine: there are no states or transitions, and the only sequential element is the optional output register.

Top module: `shift_unit`

## Requirements
- R1: Mode code 3'b000 (logical left) fills vacated low bits with zeros, so the result equals the input times 2^n modulo 2^WIDTH. Amounts of WIDTH or more give all zeros.
- R2: Mode code 3'b001 (replicating left) shifts left and sets every vacated low bit to the original bit 0. Amounts of WIDTH or more give a word made entirely of that bit.
- R3: Mode code 3'b010 (sign-holding left) keeps bit WIDTH-1 equal to the input's bit WIDTH-1, shifts bits WIDTH-2..0 left by n, and fills their vacated low positions with zeros.
- R4: In mode 3'b010, the overflow output is high exactly when the signed input times 2^n falls outside the signed WIDTH-bit range. For n below WIDTH this means some lost magnitude bit differs from the sign. For n of WIDTH or more it means the input is nonzero.
- R5: Mode code 3'b100 (arithmetic right) returns the signed input divided by 2^n, rounded toward minus infinity, with the sign bit copied into the vacated high bits.
- R6: Mode code 3'b011 (logical right) returns the unsigned input divided by 2^n, rounded down, with the vacated high bits set to zero.
- R7: A shift amount of zero returns the input unchanged in every mode and holds overflow low.
- R8: Overflow is low in every mode other than 3'b010.
- R9: Mode codes 3'b101, 3'b110 and 3'b111 return the input unchanged with overflow low.
- R10: With REG_OUT=1, the result and overflow for inputs sampled at one rising edge appear after that edge. They hold unchanged while the inputs change before the next edge.
- R11: An active-low reset clears the registered result and overflow to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | WIDTH | Data word to shift |
| amt | input | $clog2(WIDTH+1) | Shift amount |
| mode | input | 3 | Shift mode code |
| dout | output | WIDTH | Shifted result |
| ovf | output | 1 | Overflow flag for the sign-holding left mode |

## Verification
The block's only state is the output register. A wrong captured value shows on the ports for exactly the one cycle after the inputs that produced it, and a fault in the shift network shows in the first vector that uses the affected mode, amount and bit pattern. The bench sweeps every data value, every encodable amount and every mode code. This exposes fill-bit mistakes and sign-handling mistakes at the amount where they first differ, and overflow mistakes at the boundary between the lost bits that match the sign and those that do not. After every input change it also checks that the registered result has not moved before the clock edge.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [2:0] {
        SH_LSL  = 3'd0,
        SH_LREP = 3'd1,
        SH_SLA  = 3'd2,
        SH_LSR  = 3'd3,
        SH_ASR  = 3'd4
    } shift_mode_e;

endpackage

// File: rtl/shl_core.sv
module shl_core #(
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    amt,
    output logic [WIDTH-1:0] lsl,
    output logic [WIDTH-1:0] lrep,
    output logic [WIDTH-1:0] sla,
    output logic             sla_ovf
);
    localparam int MAGW = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONES  = '1;
    localparam logic [MAGW-1:0]  MONES = '1;

    logic            full_shift;
    logic [MAGW-1:0] mag_sh;
    logic [MAGW-1:0] lost_mask;
    logic [MAGW-1:0] mismatch;

    always_comb begin
        full_shift = (int'(amt) >= WIDTH);
        lsl        = din << amt;
        lrep       = lsl | (din[0] ? ~(ONES << amt) : '0);
        mag_sh     = din[MAGW-1:0] << amt;
        sla        = {din[WIDTH-1], mag_sh};
        lost_mask  = ~(MONES >> amt);
        mismatch   = (din[MAGW-1:0] ^ {MAGW{din[WIDTH-1]}}) & lost_mask;
        sla_ovf    = full_shift ? (|din) : (|mismatch);
    end

endmodule

// File: rtl/shr_core.sv
module shr_core #(
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    amt,
    output logic [WIDTH-1:0] lsr,
    output logic [WIDTH-1:0] asr
);
    always_comb begin
        lsr = din >> amt;
        asr = WIDTH'($signed(din) >>> amt);
    end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int AW     = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    amt,
    input  logic [2:0]       mode,
    output logic [WIDTH-1:0] dout,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] ONES = '1;

    logic [WIDTH-1:0] r_lsl, r_lrep, r_sla, r_lsr, r_asr;
    logic             r_sla_ovf;
    logic [WIDTH-1:0] nxt_d;
    logic             nxt_o;

    shl_core #(.WIDTH(WIDTH), .AW(AW)) u_left (
        .din(din), .amt(amt),
        .lsl(r_lsl), .lrep(r_lrep), .sla(r_sla), .sla_ovf(r_sla_ovf)
    );

    shr_core #(.WIDTH(WIDTH), .AW(AW)) u_right (
        .din(din), .amt(amt),
        .lsr(r_lsr), .asr(r_asr)
    );

    always_comb begin
        nxt_d = din;
        nxt_o = 1'b0;
        unique case (mode)
            SH_LSL:  nxt_d = r_lsl;
            SH_LREP: nxt_d = r_lrep;
            SH_SLA: begin
                nxt_d = r_sla;
                nxt_o = r_sla_ovf;
            end
            SH_LSR:  nxt_d = r_lsr;
            SH_ASR:  nxt_d = r_asr;
            default: nxt_d = din;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            logic [WIDTH-1:0] dout_q;
            logic             ovf_q;
            logic             primed;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dout_q <= '0;
                    ovf_q  <= 1'b0;
                    primed <= 1'b0;
                end else begin
                    dout_q <= nxt_d;
                    ovf_q  <= nxt_o;
                    primed <= 1'b1;
                end
            end

            assign dout = dout_q;
            assign ovf  = ovf_q;

            // R7: zero amount passes the word through
            p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
                $past(amt) == '0 |-> (dout == $past(din)) && !ovf);

            // R8: overflow only in sign-holding mode
            p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n || !primed)
                $past(mode) != SH_SLA |-> !ovf);

            // R3: sign bit stays put
            p_sign_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
                $past(mode) == SH_SLA |-> dout[WIDTH-1] == $past(din[WIDTH-1]));

            // R1: low fill is zero
            p_lsl_fill_r1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
                $past(mode) == SH_LSL |-> (dout & ~(ONES << $past(amt))) == '0);

            // R5: negative input keeps a set top bit
            p_asr_sign_r5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
                ($past(mode) == SH_ASR) && $past(din[WIDTH-1]) |-> dout[WIDTH-1]);

            // R9: undefined codes pass through
            p_undef_pass_r9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
                $past(mode) > 3'd4 |-> (dout == $past(din)) && !ovf);
        end else begin : g_comb
            assign dout = nxt_d;
            assign ovf  = nxt_o;

            always_comb begin
                if (rst_n && amt == '0)
                    a_zero_pass_r7: assert (dout == din && !ovf);
            end
        end
    endgenerate

endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
    localparam int W  = 8;
    localparam int AW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  din = '0;
    logic [AW-1:0] amt = '0;
    logic [2:0]    mode = '0;
    logic [W-1:0]  dout;
    logic          ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    shift_unit #(.WIDTH(W), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .amt(amt), .mode(mode),
        .dout(dout), .ovf(ovf)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: din=%h amt=%0d mode=%0d actual=%h expected=%h",
                     tag, din, amt, mode, act, exp);
        end
    endtask

    // arithmetic reference model
    task automatic model(input logic [W-1:0] d, input int n, input int m,
                         output logic [W-1:0] r, output logic o);
        longint u, s, p, q, mask, prod;
        u = longint'(d);
        s = longint'($signed(d));
        p = longint'(1) << n;
        mask = (n >= W) ? ((longint'(1) << W) - 1) : (p - 1);
        o = 1'b0;
        case (m)
            0: r = W'((u * p) % (longint'(1) << W));
            1: r = W'((u * p) % (longint'(1) << W)) | (d[0] ? W'(mask) : '0);
            2: begin
                r = {d[W-1], (W-1)'(((u % (longint'(1) << (W-1))) * p) % (longint'(1) << (W-1)))};
                prod = s * p;
                o = (prod > ((longint'(1) << (W-1)) - 1)) || (prod < -(longint'(1) << (W-1)));
            end
            3: r = W'(u / p);
            4: begin
                q = s / p;
                if (s < 0 && (s % p) != 0) q = q - 1;
                r = W'(q);
            end
            default: r = d;
        endcase
    endtask

    function automatic string data_tag(input int m, input int n);
        if (n == 0) return "R7";
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R6";
            4: return "R5";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #(64'd200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp_d, prev_d;
        logic         exp_o, prev_o;

        // R11: reset clears output even with active inputs
        din  = 8'hA5;
        amt  = 4'd3;
        mode = 3'd2;
        repeat (3) @(negedge clk);
        check("R11", dout, '0);
        check("R11", W'(ovf), '0);
        @(negedge clk);
        rst_n = 1'b1;

        prev_d = '0;
        prev_o = 1'b0;
        for (int m = 0; m < 8; m++) begin
            for (int n = 0; n < (1 << AW); n++) begin
                for (int d = 0; d < (1 << W); d++) begin
                    din  = W'(d);
                    amt  = AW'(n);
                    mode = 3'(m);
                    #2;
                    // R10: no change before the capturing edge
                    check("R10", dout, prev_d);
                    check("R10", W'(ovf), W'(prev_o));
                    @(negedge clk);
                    model(W'(d), n, m, exp_d, exp_o);
                    check(data_tag(m, n), dout, exp_d);
                    check((m == 2) ? "R4" : "R8", W'(ovf), W'(exp_o));
                    prev_d = exp_d;
                    prev_o = exp_o;
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule